// File: doc/BRIEF.md
# Byte-Lane Steering Unit for 16-bit Word Memory

This unit sits between a processor that issues byte or word accesses and a local memory built from 16-bit words. It registers one request per cycle. From that request it produces the word address, two byte-lane enables and the write data placed on the correct lane. For byte reads, it also extracts the addressed byte from the returned memory word and right-justifies it on the processor read bus.

Lane mapping is big-endian. A byte at an even address lives in the upper half of the word, bits 15:8. A byte at an odd address lives in the lower half, bits 7:0.

Word accesses must be even. A word request with address bit 0 set is refused. The unit raises an error pulse for that request, and no lane is enabled.

Top module: `bls_steer`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_valid`, `mem_we`, `mem_lane_en` and `misalign_err` are all zero.
- R2: One clock after an accepted request, `mem_valid` is 1 and `mem_waddr` equals the request byte address shifted right by one bit.
- R3: An accepted word request (`req_byte`=0, address bit 0 = 0) enables both lanes (`mem_lane_en`=2'b11) and passes `req_wdata` to `mem_wdata` unchanged.
- R4: A byte request with address bit 0 = 0 enables only the upper lane: `mem_lane_en`=2'b10, where bit 1 gates data bits 15:8.
- R5: A byte request with address bit 0 = 1 enables only the lower lane: `mem_lane_en`=2'b01, where bit 0 gates data bits 7:0.
- R6: For a byte write, `mem_wdata` carries `req_wdata[7:0]` in both halves. A byte write changes only the enabled byte of the stored word.
- R7: During a byte read (`mem_valid`=1, `mem_we`=0), `cpu_rdata[7:0]` is the selected byte of `mem_rdata`, and `cpu_rdata[15:8]` is zero.
- R8: During a word read, `cpu_rdata` equals `mem_rdata`.
- R9: A word request with address bit 0 = 1 sets `misalign_err` for exactly the following cycle. In that cycle `mem_valid`, `mem_we` and `mem_lane_en` stay zero, and the stored word is unchanged.
- R10: One clock after a cycle with `req_valid`=0, `mem_valid`=0, `mem_lane_en`=0 and `misalign_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Byte address |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| mem_rdata | input | 16 | Word returned by memory for `mem_waddr` |
| mem_valid | output | 1 | Memory access in progress |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | ADDR_W-1 (15) | Word address |
| mem_lane_en | output | 2 | Lane enables: bit 1 = bits 15:8, bit 0 = bits 7:0 |
| mem_wdata | output | 16 | Lane-steered write data |
| cpu_rdata | output | 16 | Steered read data to the processor |
| misalign_err | output | 1 | One-cycle pulse for a refused odd word access |

## Verification
The bench builds the unit with its defaults: a 16-bit byte address and 8-bit lanes. That gives two lanes and a 15-bit word address. With these values, the upper address bits reach `mem_waddr` through the shift.

A 16-word memory model behind the unit lets the bench check sequences that depend on order. It writes one byte and then reads back its neighbour. It issues a refused odd word write and then reads the target word to confirm nothing changed. It also sends back-to-back byte and word requests with idle gaps between them.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int unsigned LANES = 2;

  // Lane enable for an access: bit 1 gates the upper byte, bit 0 the lower.
  function automatic logic [LANES-1:0] lane_mask(input logic is_byte, input logic a0);
    if (!is_byte) return 2'b11;
    return a0 ? 2'b01 : 2'b10;
  endfunction

  // A word access must be even.
  function automatic logic is_misaligned(input logic is_byte, input logic a0);
    return !is_byte && a0;
  endfunction
endpackage

// File: rtl/bls_lane_decode.sv
module bls_lane_decode
  import bls_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              valid,
  input  logic              is_byte,
  input  logic [ADDR_W-1:0] addr,
  output logic [LANES-1:0]  lane_en,
  output logic              misalign,
  output logic              accept,
  output logic [ADDR_W-2:0] word_addr
);
  always_comb begin
    misalign  = valid && is_misaligned(is_byte, addr[0]);
    accept    = valid && !misalign;
    lane_en   = accept ? lane_mask(is_byte, addr[0]) : '0;
    word_addr = addr[ADDR_W-1:1];
  end
endmodule

// File: rtl/bls_wdata_pack.sv
module bls_wdata_pack
  import bls_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DATA_W = BYTE_W * LANES
) (
  input  logic              is_byte,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dout[i*BYTE_W +: BYTE_W] = is_byte ? din[BYTE_W-1:0] : din[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/bls_rdata_extract.sv
module bls_rdata_extract
  import bls_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DATA_W = BYTE_W * LANES
) (
  input  logic              is_byte,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] dout
);
  logic [BYTE_W-1:0] picked;

  always_comb begin
    picked = lane_en[1] ? word_in[DATA_W-1 -: BYTE_W] : word_in[BYTE_W-1:0];
    dout   = is_byte ? {{(DATA_W-BYTE_W){1'b0}}, picked} : word_in;
  end
endmodule

// File: rtl/bls_steer.sv
module bls_steer
  import bls_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DATA_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_byte,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-2:0] mem_waddr,
  output logic [LANES-1:0]  mem_lane_en,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              misalign_err
);
  // Named internal events for checking
  logic              dec_accept;
  logic              dec_misalign;
  logic [LANES-1:0]  dec_lane;
  logic [ADDR_W-2:0] dec_waddr;
  logic [DATA_W-1:0] packed_wdata;
  logic              byte_q;

  bls_lane_decode #(.ADDR_W(ADDR_W)) u_decode (
    .valid     (req_valid),
    .is_byte   (req_byte),
    .addr      (req_addr),
    .lane_en   (dec_lane),
    .misalign  (dec_misalign),
    .accept    (dec_accept),
    .word_addr (dec_waddr)
  );

  bls_wdata_pack #(.BYTE_W(BYTE_W)) u_pack (
    .is_byte (req_byte),
    .din     (req_wdata),
    .dout    (packed_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid    <= 1'b0;
      mem_we       <= 1'b0;
      mem_waddr    <= '0;
      mem_lane_en  <= '0;
      mem_wdata    <= '0;
      misalign_err <= 1'b0;
      byte_q       <= 1'b0;
    end else begin
      mem_valid    <= dec_accept;
      mem_we       <= dec_accept && req_write;
      mem_lane_en  <= dec_lane;
      misalign_err <= dec_misalign;
      if (dec_accept) begin
        mem_waddr <= dec_waddr;
        mem_wdata <= packed_wdata;
        byte_q    <= req_byte;
      end
    end
  end

  bls_rdata_extract #(.BYTE_W(BYTE_W)) u_extract (
    .is_byte (byte_q),
    .lane_en (mem_lane_en),
    .word_in (mem_rdata),
    .dout    (cpu_rdata)
  );

  // Assertions
  a_r2_waddr_shift: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_waddr == $past(req_addr[ADDR_W-1:1]));
  a_r3_word_both_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !byte_q) |-> mem_lane_en == 2'b11);
  a_r4_r5_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && byte_q) |-> $onehot(mem_lane_en));
  a_r6_byte_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && byte_q) |-> mem_wdata[DATA_W-1 -: BYTE_W] == mem_wdata[BYTE_W-1:0]);
  a_r7_byte_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && byte_q) |-> cpu_rdata[DATA_W-1:BYTE_W] == '0);
  a_r9_err_blocks_access: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> (!mem_valid && !mem_we && mem_lane_en == '0));
  a_r9_err_from_odd_word: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> ($past(req_valid) && !$past(req_byte) && $past(req_addr[0])));
  a_r10_idle_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> mem_lane_en == '0);
endmodule

// File: tb/tb_bls_steer.sv
module tb_bls_steer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_byte = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [15:0] mem_rdata;
  logic        mem_valid, mem_we, misalign_err;
  logic [14:0] mem_waddr;
  logic [1:0]  mem_lane_en;
  logic [15:0] mem_wdata, cpu_rdata;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bls_steer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_byte(req_byte),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_rdata(mem_rdata), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_lane_en(mem_lane_en), .mem_wdata(mem_wdata),
    .cpu_rdata(cpu_rdata), .misalign_err(misalign_err)
  );

  // Memory model: 16 words, indexed by the low word-address bits
  logic [15:0] mem [16];
  logic [15:0] shadow [16];
  assign mem_rdata = mem[mem_waddr[3:0]];

  always @(posedge clk) begin
    if (mem_valid && mem_we) begin
      if (mem_lane_en[1]) mem[mem_waddr[3:0]][15:8] <= mem_wdata[15:8];
      if (mem_lane_en[0]) mem[mem_waddr[3:0]][7:0]  <= mem_wdata[7:0];
    end
  end

  typedef struct {
    string       tag;
    logic        v;
    logic        we;
    logic [14:0] wa;
    logic [1:0]  ln;
    logic [15:0] wd;
    logic        chk_wd;
    logic [15:0] rd;
    logic        chk_rd;
    logic        err;
  } exp_t;

  exp_t q[$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: drives one request per cycle and pushes its expectation
  task automatic drive(input logic vld, input logic isb, input logic wr,
                       input logic [15:0] a, input logic [15:0] d, input string tag);
    exp_t e;
    logic ok, mis;
    logic [3:0] idx;
    @(negedge clk);
    req_valid = vld; req_byte = isb; req_write = wr; req_addr = a; req_wdata = d;
    mis = vld && !isb && a[0];
    ok  = vld && !mis;
    idx = a[4:1];
    e.tag = tag;
    e.v   = ok;
    e.we  = ok && wr;
    e.wa  = a[15:1];
    e.ln  = !ok ? 2'b00 : (!isb ? 2'b11 : (a[0] ? 2'b01 : 2'b10));
    e.wd  = isb ? {d[7:0], d[7:0]} : d;
    e.chk_wd = ok && wr;
    e.rd  = !isb ? shadow[idx] : (a[0] ? {8'h00, shadow[idx][7:0]} : {8'h00, shadow[idx][15:8]});
    e.chk_rd = ok && !wr;
    e.err = mis;
    if (ok && wr) begin
      if (e.ln[1]) shadow[idx][15:8] = d[isb ? 7 : 15 -: 8];
      if (e.ln[0]) shadow[idx][7:0]  = d[7:0];
    end
    q.push_back(e);
  endtask

  // Monitor: compares one expectation per cycle, after the edge settles
  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, 64'(mem_valid), 64'(e.v), "mem_valid");
      check(e.tag, 64'(mem_we), 64'(e.we), "mem_we");
      check(e.tag, 64'(mem_lane_en), 64'(e.ln), "mem_lane_en");
      check(e.tag, 64'(misalign_err), 64'(e.err), "misalign_err");
      if (e.v) check(e.tag, 64'(mem_waddr), 64'(e.wa), "mem_waddr");
      if (e.chk_wd) check(e.tag, 64'(mem_wdata), 64'(e.wd), "mem_wdata");
      if (e.chk_rd) check(e.tag, 64'(cpu_rdata), 64'(e.rd), "cpu_rdata");
    end
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]    = 16'hA000 + 16'(i * 16'h0111);
      shadow[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", 64'({mem_valid, mem_we, mem_lane_en, misalign_err}), 64'(0), "outputs in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", 64'({mem_valid, mem_we, mem_lane_en, misalign_err}), 64'(0), "outputs after reset");

    drive(1, 0, 1, 16'h0004, 16'hBEEF, "R3_word_write");
    drive(1, 0, 0, 16'h0004, 16'h0000, "R8_word_read");
    drive(1, 1, 1, 16'h0006, 16'h0012, "R4_R6_byte_write_even");
    drive(1, 1, 1, 16'h0007, 16'h0034, "R5_R6_byte_write_odd");
    drive(1, 1, 0, 16'h0006, 16'h0000, "R4_R7_byte_read_even");
    drive(1, 1, 0, 16'h0007, 16'h0000, "R5_R7_byte_read_odd");
    drive(1, 0, 0, 16'h0006, 16'h0000, "R8_word_read_merged");
    drive(0, 0, 0, 16'h0000, 16'h0000, "R10_idle");
    drive(1, 0, 1, 16'h0009, 16'h5555, "R9_misaligned_write");
    drive(1, 0, 0, 16'h0008, 16'h0000, "R9_target_unchanged");
    drive(1, 0, 0, 16'h0003, 16'h0000, "R9_misaligned_read");
    drive(1, 0, 1, 16'hFFFF, 16'h1111, "R9_misaligned_top");
    drive(0, 1, 1, 16'h0002, 16'hFFFF, "R10_idle_ignored");
    drive(1, 0, 0, 16'h0002, 16'h0000, "R10_idle_write_ignored");
    drive(1, 1, 0, 16'hFFFE, 16'h0000, "R2_R4_high_address");
    drive(1, 1, 1, 16'h8ABD, 16'h00C3, "R2_R5_high_address_write");
    drive(1, 0, 0, 16'h8ABC, 16'h0000, "R2_R6_only_low_lane");
    for (int i = 0; i < 32; i++) begin
      drive(1, 1, 1, 16'(16'h4000 + i), 16'(8'h10 + i), (i[0] ? "R5_R6_sweep" : "R4_R6_sweep"));
    end
    for (int i = 0; i < 32; i++) begin
      drive(1, 1, 0, 16'(16'h4000 + i), 16'h0000, "R7_sweep");
    end
    for (int i = 0; i < 16; i++) begin
      drive(1, 0, 0, 16'(16'h4000 + 2 * i), 16'h0000, "R3_R8_sweep");
    end
    drive(0, 0, 0, 16'h0000, 16'h0000, "R10_tail");
    drive(0, 0, 0, 16'h0000, 16'h0000, "R10_tail");
    @(negedge clk);
    req_valid = 1'b0;
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule